// File: doc/BRIEF.md
# Deterministic Instruction Counter and Sync Arbiter

This block keeps one retired-instruction counter for each of `N` hardware threads. Each counter has its own start and stop pulses. Any counter can be read through a shared select port or through the flat count bus. A programmable quantum length, in instructions, is shared by all threads. When a running counter reaches that length, the thread traps and its counter stops until it is started again.

The block also decides when a thread may perform an atomic or synchronizing operation. A requesting thread receives the single grant only when its count is the smallest among all running threads. Ties go to the lowest thread index. The outcome therefore depends on how far each thread has progressed, not on when its request arrived.

A requester that is not yet the minimum waits with its counter frozen. The other threads keep running and eventually pass it. The grant lasts as long as the winning thread keeps its request raised.

Top module: `ic_quantum_arb`

## Requirements
- R1: After reset, every count is zero, no thread is running, no trap is raised and no grant is given.
- R2: A start pulse for a thread has these effects at the next edge:
  - its count becomes zero;
  - its trap flag is cleared;
  - the thread is marked running.
  A start pulse wins over a stop pulse given to the same thread in the same cycle.
- R3: A running thread's count rises by exactly one at each edge where its retire pulse is high. Retire pulses to a thread that is not running leave its count unchanged.
- R4: A stop pulse clears the running flag of a running thread at the next edge and leaves its count unchanged.
- R5: `rd_count_o` shows, in the same cycle, the count of the thread whose index is on `rd_sel_i`.
- R6: Suppose a counted retire makes a thread's count equal to or greater than `quantum_i`. At that same edge the thread's trap bit rises and its running bit falls. The trap stays raised, and the count stays fixed, until the thread is started again.
- R7: A grant is raised one cycle after the request is seen. It goes only to a running requester whose count is the minimum over all running threads, and only when no grant is currently held.
- R8: When several running threads share the minimum count, only the lowest-indexed of them can be granted.
- R9: Threads that are stopped or trapped take no part in the minimum comparison, even when their count is smaller.
- R10: A thread whose request is raised but not granted ignores its retire pulses. It stays waiting until it becomes the minimum.
- R11: At most one grant is high at any time. A grant stays high while its request stays high. It falls one cycle after the request falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | N | Per-thread retired-instruction pulse |
| start_i | input | N | Per-thread start pulse (zero count, run) |
| stop_i | input | N | Per-thread stop pulse |
| quantum_i | input | W | Quantum length in instructions |
| sync_req_i | input | N | Per-thread atomic/sync request level |
| rd_sel_i | input | $clog2(N) | Thread index for the read port |
| rd_count_o | output | W | Count of the selected thread |
| count_o | output | N*W | All counts, thread i in bits [i*W +: W] |
| running_o | output | N | Per-thread running flag |
| trap_o | output | N | Per-thread quantum-reached trap |
| sync_gnt_o | output | N | One-hot sync grant |

## Verification
The assertions assume that a thread asking to synchronize holds its request level until it has been granted and is done, and that `quantum_i` does not change while threads are counting. The trap check compares the count with the quantum of the previous cycle. The stimulus keeps the quantum fixed for the whole run and drops requests only after a grant, except in the non-minimum waiting case, where the request is held until the grant arrives. Inputs stay low during reset, so the grant-origin checks see clean request history from the first edge.

// File: rtl/ic_pkg.sv
package ic_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_TRAP = 2'd2
  } thr_state_e;

endpackage

// File: rtl/ic_thread_ctr.sv
module ic_thread_ctr
  import ic_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         retire_i,
  input  logic         hold_i,
  input  logic [W-1:0] quantum_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         trapped_o
);

  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  thr_state_e   st_q, st_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cnt_inc;
  logic         cnt_en;
  logic         st_en;
  logic         step_ok;

  assign cnt_inc = cnt_q + ONE_W;
  assign step_ok = (st_q == TS_RUN) && retire_i && !hold_i && !stop_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    st_en  = 1'b0;
    if (start_i) begin
      st_d   = TS_RUN;
      cnt_d  = '0;
      cnt_en = 1'b1;
      st_en  = 1'b1;
    end else if (stop_i && (st_q == TS_RUN)) begin
      st_d  = TS_IDLE;
      st_en = 1'b1;
    end else if (step_ok) begin
      cnt_d  = cnt_inc;
      cnt_en = 1'b1;
      if (cnt_inc >= quantum_i) begin
        st_d  = TS_TRAP;
        st_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TS_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o   = cnt_q;
  assign running_o = (st_q == TS_RUN);
  assign trapped_o = (st_q == TS_TRAP);

endmodule

// File: rtl/ic_min_sel.sv
module ic_min_sel #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 20
) (
  input  logic [N*W-1:0] counts_i,
  input  logic [N-1:0]   valid_i,
  output logic [N-1:0]   min_onehot_o
);

  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0]  best_val;
  logic [IW-1:0] best_idx;
  logic          found;

  always_comb begin
    best_val = '0;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i]) begin
        if (!found || (counts_i[i*W +: W] < best_val)) begin
          best_val = counts_i[i*W +: W];
          best_idx = IW'(i);
          found    = 1'b1;
        end
      end
    end
  end

  always_comb begin
    min_onehot_o = '0;
    if (found) begin
      min_onehot_o[best_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/ic_sync_arb.sv
module ic_sync_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] min_onehot_i,
  output logic [N-1:0] gnt_o
);

  logic [N-1:0] gnt_q, gnt_d;
  logic         held;
  logic         gnt_en;

  assign held   = |gnt_q;
  assign gnt_en = held || (|(req_i & min_onehot_i));

  always_comb begin
    if (held) begin
      gnt_d = gnt_q & req_i;
    end else begin
      gnt_d = req_i & min_onehot_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;

endmodule

// File: rtl/ic_quantum_arb.sv
module ic_quantum_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 20,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   retire_i,
  input  logic [N-1:0]   start_i,
  input  logic [N-1:0]   stop_i,
  input  logic [W-1:0]   quantum_i,
  input  logic [N-1:0]   sync_req_i,
  input  logic [SW-1:0]  rd_sel_i,
  output logic [W-1:0]   rd_count_o,
  output logic [N*W-1:0] count_o,
  output logic [N-1:0]   running_o,
  output logic [N-1:0]   trap_o,
  output logic [N-1:0]   sync_gnt_o
);

  logic [N-1:0] gnt;
  logic [N-1:0] hold;
  logic [N-1:0] min_oh;

  assign hold = sync_req_i & ~gnt;

  for (genvar g = 0; g < N; g++) begin : g_thr
    ic_thread_ctr #(.W(W)) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i[g]),
      .stop_i    (stop_i[g]),
      .retire_i  (retire_i[g]),
      .hold_i    (hold[g]),
      .quantum_i (quantum_i),
      .count_o   (count_o[g*W +: W]),
      .running_o (running_o[g]),
      .trapped_o (trap_o[g])
    );
  end

  ic_min_sel #(.N(N), .W(W)) min_i (
    .counts_i     (count_o),
    .valid_i      (running_o),
    .min_onehot_o (min_oh)
  );

  ic_sync_arb #(.N(N)) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (sync_req_i),
    .min_onehot_i (min_oh),
    .gnt_o        (gnt)
  );

  always_comb begin
    rd_count_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel_i == SW'(i)) begin
        rd_count_o = count_o[i*W +: W];
      end
    end
  end

  assign sync_gnt_o = gnt;

endmodule

// File: rtl/ic_quantum_arb_chk.sv
module ic_quantum_arb_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   start_i,
  input logic [W-1:0]   quantum_i,
  input logic [N-1:0]   sync_req_i,
  input logic [N*W-1:0] count_o,
  input logic [N-1:0]   running_o,
  input logic [N-1:0]   trap_o,
  input logic [N-1:0]   sync_gnt_o
);

  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  logic [N-1:0] ok_min;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ok_min[i] = running_o[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && running_o[j]) begin
          if (j < i) begin
            ok_min[i] = ok_min[i] && (count_o[i*W +: W] < count_o[j*W +: W]);
          end else begin
            ok_min[i] = ok_min[i] && (count_o[i*W +: W] <= count_o[j*W +: W]);
          end
        end
      end
    end
  end

  // R11
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_gnt_o));

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i[g] |=> ((count_o[g*W +: W] == $past(count_o[g*W +: W])) ||
                       (count_o[g*W +: W] == $past(count_o[g*W +: W]) + ONE_W)));
    // R10
    wait_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req_i[g] && !sync_gnt_o[g] && !start_i[g]) |=>
        (count_o[g*W +: W] == $past(count_o[g*W +: W])));
    // R6
    trap_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o[g] |-> !running_o[g]);
    // R6
    trap_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_o[g]) |-> (count_o[g*W +: W] >= $past(quantum_i)));
    // R7
    grant_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_gnt_o[g]) |-> ($past(sync_req_i[g]) && $past(ok_min[g]) &&
                                ($past(sync_gnt_o) == '0)));
    // R11
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_gnt_o[g] && sync_req_i[g]) |=> sync_gnt_o[g]);
    // R11
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_gnt_o[g] && !sync_req_i[g]) |=> !sync_gnt_o[g]);
  end

endmodule

bind ic_quantum_arb ic_quantum_arb_chk #(.N(N), .W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .quantum_i  (quantum_i),
  .sync_req_i (sync_req_i),
  .count_o    (count_o),
  .running_o  (running_o),
  .trap_o     (trap_o),
  .sync_gnt_o (sync_gnt_o)
);

// File: tb/ic_quantum_arb_tb.sv
module ic_quantum_arb_tb_top;

  localparam int unsigned N = 4;
  localparam int unsigned W = 20;

  typedef struct {
    int          cyc;
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   retire_r, start_r, stop_r, req_r;
  logic [W-1:0]   quantum_r;
  logic [1:0]     rd_sel_r;
  logic [W-1:0]   rd_count;
  logic [N*W-1:0] counts;
  logic [N-1:0]   running, trap, gnt;

  exp_item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  ic_quantum_arb #(.N(N), .W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_r),
    .start_i    (start_r),
    .stop_i     (stop_r),
    .quantum_i  (quantum_r),
    .sync_req_i (req_r),
    .rd_sel_i   (rd_sel_r),
    .rd_count_o (rd_count),
    .count_o    (counts),
    .running_o  (running),
    .trap_o     (trap),
    .sync_gnt_o (gnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int kind, int idx);
    case (kind)
      0: observe = 32'(counts[idx*W +: W]);
      1: observe = 32'(running);
      2: observe = 32'(trap);
      3: observe = 32'(gnt);
      default: observe = 32'(rd_count);
    endcase
  endfunction

  // monitor: pops expectations due at this sample point
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = observe(it.kind, it.idx);
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d idx=%0d actual=%0d expected=%0d",
                 it.tag, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic expect_next(int kind, int idx, logic [31:0] v, string tag);
    exp_item_t it;
    it.cyc = cyc + 1;
    it.kind = kind;
    it.idx = idx;
    it.exp = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_counts(int c0, int c1, int c2, int c3, string tag);
    expect_next(0, 0, 32'(c0), tag);
    expect_next(0, 1, 32'(c1), tag);
    expect_next(0, 2, 32'(c2), tag);
    expect_next(0, 3, 32'(c3), tag);
  endtask

  task automatic step(logic [N-1:0] st, logic [N-1:0] sp,
                      logic [N-1:0] rt, logic [N-1:0] rq);
    start_r  = st;
    stop_r   = sp;
    retire_r = rt;
    req_r    = rq;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    retire_r = '0; start_r = '0; stop_r = '0; req_r = '0;
    quantum_r = W'(10);
    rd_sel_r = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_counts(0, 0, 0, 0, "R1");
    expect_next(1, 0, 0, "R1");
    expect_next(2, 0, 0, "R1");
    expect_next(3, 0, 0, "R1");
    step('0, '0, '0, '0);

    // R2 start all
    expect_counts(0, 0, 0, 0, "R2");
    expect_next(1, 0, 32'hF, "R2");
    step(4'hF, '0, '0, '0);

    // R3 counting patterns
    expect_counts(1, 1, 1, 0, "R3");
    step('0, '0, 4'b0111, '0);
    expect_counts(2, 2, 2, 0, "R3");
    step('0, '0, 4'b0111, '0);
    expect_counts(3, 2, 2, 0, "R3");
    step('0, '0, 4'b0001, '0);

    // R5 read port (rd_sel stays 0 for the run)
    expect_next(4, 0, 3, "R5");
    step('0, '0, '0, '0);

    // R4 stop thread 3
    expect_next(1, 0, 32'b0111, "R4");
    expect_counts(3, 2, 2, 0, "R4");
    step('0, 4'b1000, '0, '0);
    expect_counts(4, 3, 3, 0, "R3 stopped ignores retire");
    step('0, '0, 4'hF, '0);
    expect_counts(5, 4, 4, 0, "R3 stopped ignores retire");
    step('0, '0, 4'hF, '0);

    // R8/R9 tie t1,t2; stopped t3 with count 0 excluded
    expect_next(3, 0, 32'b0010, "R8 R9");
    expect_counts(6, 4, 4, 0, "R10");
    step('0, '0, 4'b0001, 4'b0110);
    // R11 held; R10 t2 frozen while waiting
    expect_next(3, 0, 32'b0010, "R11");
    expect_counts(7, 5, 4, 0, "R10");
    step('0, '0, 4'b0111, 4'b0110);
    expect_next(3, 0, 32'b0000, "R11 release");
    step('0, '0, '0, 4'b0100);
    expect_next(3, 0, 32'b0100, "R7");
    step('0, '0, '0, 4'b0100);
    expect_next(3, 0, 32'b0000, "R11 release");
    step('0, '0, '0, '0);

    // R10 non-minimum t0 waits frozen
    expect_next(3, 0, 0, "R10");
    expect_counts(7, 6, 5, 0, "R10");
    step('0, '0, 4'b0111, 4'b0001);
    expect_next(3, 0, 0, "R10");
    expect_counts(7, 7, 6, 0, "R10");
    step('0, '0, 4'b0111, 4'b0001);
    expect_next(3, 0, 0, "R10");
    expect_counts(7, 8, 7, 0, "R10");
    step('0, '0, 4'b0111, 4'b0001);
    expect_next(3, 0, 32'b0001, "R8 R7 tie t0/t2");
    step('0, '0, '0, 4'b0001);
    expect_next(3, 0, 0, "R11 release");
    step('0, '0, '0, '0);

    // R6 quantum trap at 10
    expect_next(0, 0, 8, "R6");
    expect_next(2, 0, 0, "R6");
    step('0, '0, 4'b0001, '0);
    expect_next(0, 0, 9, "R6");
    step('0, '0, 4'b0001, '0);
    expect_next(0, 0, 10, "R6");
    expect_next(2, 0, 32'b0001, "R6");
    expect_next(1, 0, 32'b0110, "R6");
    step('0, '0, 4'b0001, '0);
    expect_next(0, 0, 10, "R6 held");
    expect_next(2, 0, 32'b0001, "R6 held");
    step('0, '0, 4'b0001, '0);
    expect_next(3, 0, 32'b0100, "R9 R7");
    step('0, '0, '0, 4'b0100);
    expect_next(3, 0, 0, "R11 release");
    step('0, '0, '0, '0);

    // R2 start wins over stop, clears trap
    expect_next(0, 0, 0, "R2");
    expect_next(2, 0, 0, "R2");
    expect_next(1, 0, 32'b0111, "R2");
    expect_next(4, 0, 0, "R5");
    step(4'b0001, 4'b0001, '0, '0);
    expect_next(1, 0, 32'hF, "R2");
    expect_next(0, 3, 0, "R2");
    step(4'b1000, '0, '0, '0);

    step('0, '0, '0, '0);
    step('0, '0, '0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule